// File: doc/BRIEF.md
# Video Rate Hunt Controller

This block searches for the data rate of an incoming serial video stream. It drives a 2-bit standard-select code to an external receiver. It keeps that code for a programmable number of clock cycles (the dwell). It then moves to the next code, wraps after the last one, and repeats. Each code names one candidate standard: 4:2:2 component at 270 Mb/s, 4:2:2 component at 360 Mb/s, 4fsc composite NTSC, or 4fsc composite PAL.

The search pauses in two cases. The first is when the receiver reports no carrier. The second is when the downstream decoder reports a valid timing reference, which means the current code is correct. A reported timing reference locks the code for a programmable hold time. Each further timing reference restarts that hold time. If the hold time runs out with no new reference, the search resumes from the code that was locked.

Top module: `rate_hunt_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `std_sel` is 2'b00. The dwell count starts from zero, so the first step comes a full dwell after reset.
- R2: Each step moves `std_sel` exactly one place along the wrapping order 2'b00 (4:2:2 270 Mb/s), 2'b01 (4:2:2 360 Mb/s), 2'b10 (4fsc NTSC), 2'b11 (4fsc PAL), then back to 2'b00.
- R3: While hunting, a step happens on every `dwell_len`-th hunting clock edge. The dwell count restarts at zero on every step.
- R4: While `carrier_ok` is low, `std_sel` does not change. The dwell count is cleared, so a full dwell passes after the carrier returns before the next step.
- R5: A clock edge with `ref_seen` high locks the controller. While locked, `std_sel` does not change and the dwell count stays at zero.
- R6: The lock releases `hold_len` edges after the last `ref_seen` edge. Hunting then resumes from the held code. A `ref_seen` during the lock reloads the full hold time.
- R7: A `dwell_len` of zero acts as one, so the code steps on every hunting edge. A `hold_len` of zero acts as one.
- R8: No step happens on an edge where `ref_seen` is high, even if the dwell expires on that edge.
- R9: Loss of carrier does not cancel or extend a lock. The hold time keeps counting while `carrier_ok` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| carrier_ok | input | 1 | High while the receiver sees a carrier |
| ref_seen | input | 1 | One-cycle pulse: valid timing reference found |
| dwell_len | input | DWELL_W | Hunting cycles spent on each code |
| hold_len | input | HOLD_W | Lock duration after a timing reference, in cycles |
| std_sel | output | 2 | Standard-select code sent to the receiver |

## Verification
The hardest case to reach is a timing reference that arrives on the very edge where the dwell would expire. A close second is a lock whose hold time runs out while the carrier is absent. The stimulus counts cycles from reset and from each step to place `ref_seen` pulses on exact edges. It drops the carrier partway through a lock. Every cycle is compared against a reference model of the requirements. This confirms that the held code and the restarted dwell both come out right when the lock releases.

// File: rtl/rate_hunt_pkg.sv
package rate_hunt_pkg;

    // Candidate standards, in hunt order. The receiver decodes these values.
    typedef enum logic [1:0] {
        STD_CMP270 = 2'b00,
        STD_CMP360 = 2'b01,
        STD_NTSC   = 2'b10,
        STD_PAL    = 2'b11
    } std_code_e;

    // Hunt state shared between the submodules.
    typedef struct packed {
        logic hunt_en;
        logic locked;
        logic step;
    } hunt_ctl_t;

    localparam int DEF_DWELL_W = 16;
    localparam int DEF_HOLD_W  = 20;

    function automatic std_code_e next_std(input std_code_e cur);
        case (cur)
            STD_CMP270: next_std = STD_CMP360;
            STD_CMP360: next_std = STD_NTSC;
            STD_NTSC:   next_std = STD_PAL;
            default:    next_std = STD_CMP270;
        endcase
    endfunction

endpackage

// File: rtl/hunt_dwell_timer.sv
module hunt_dwell_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] len,
    output logic         expire
);
    logic [W-1:0] cnt;
    logic [W-1:0] len_eff;

    assign len_eff = (len == '0) ? W'(1) : len;
    assign expire  = run && (cnt == len_eff - W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (!run || expire)
            cnt <= '0;
        else
            cnt <= cnt + W'(1);
    end

    // R3: the count restarts after each expiry
    p_dwell_restart_r3: assert property (@(posedge clk) disable iff (rst)
        expire |=> (cnt == '0));
    // R4/R5: the count is cleared whenever hunting is paused
    p_dwell_clear_r4: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

endmodule

// File: rtl/hunt_lock_timer.sv
module hunt_lock_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ref_hit,
    input  logic [W-1:0] len,
    output logic         locked
);
    logic [W-1:0] hold_cnt;
    logic [W-1:0] len_eff;

    assign len_eff = (len == '0) ? W'(1) : len;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked   <= 1'b0;
            hold_cnt <= '0;
        end else if (ref_hit) begin
            locked   <= 1'b1;
            hold_cnt <= len_eff;
        end else if (locked) begin
            if (hold_cnt == W'(1)) begin
                locked   <= 1'b0;
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt - W'(1);
            end
        end
    end

    p_lock_on_ref_r5: assert property (@(posedge clk) disable iff (rst)
        ref_hit |=> locked);
    p_lock_release_r6: assert property (@(posedge clk) disable iff (rst)
        (locked && !ref_hit && hold_cnt == W'(1)) |=> !locked);

endmodule

// File: rtl/hunt_code_stepper.sv
module hunt_code_stepper
    import rate_hunt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      step,
    output std_code_e code
);
    always_ff @(posedge clk) begin
        if (rst)
            code <= STD_CMP270;
        else if (step)
            code <= next_std(code);
    end

    p_step_order_r2: assert property (@(posedge clk) disable iff (rst)
        step |=> (code == next_std($past(code))));
    p_idle_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(code));

endmodule

// File: rtl/rate_hunt_ctrl.sv
module rate_hunt_ctrl
    import rate_hunt_pkg::*;
#(
    parameter int DWELL_W = DEF_DWELL_W,
    parameter int HOLD_W  = DEF_HOLD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               carrier_ok,
    input  logic               ref_seen,
    input  logic [DWELL_W-1:0] dwell_len,
    input  logic [HOLD_W-1:0]  hold_len,
    output logic [1:0]         std_sel
);
    hunt_ctl_t ctl;
    std_code_e code;

    // Hunt only with a carrier, no lock, and no reference on this edge (R8).
    assign ctl.hunt_en = carrier_ok && !ctl.locked && !ref_seen;

    hunt_lock_timer #(.W(HOLD_W)) u_lock (
        .clk     (clk),
        .rst     (rst),
        .ref_hit (ref_seen),
        .len     (hold_len),
        .locked  (ctl.locked)
    );

    hunt_dwell_timer #(.W(DWELL_W)) u_dwell (
        .clk    (clk),
        .rst    (rst),
        .run    (ctl.hunt_en),
        .len    (dwell_len),
        .expire (ctl.step)
    );

    hunt_code_stepper u_code (
        .clk  (clk),
        .rst  (rst),
        .step (ctl.step),
        .code (code)
    );

    assign std_sel = code;

    p_carrier_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !carrier_ok |=> $stable(std_sel));
    p_ref_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        ref_seen |=> $stable(std_sel));
    p_locked_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        ctl.locked |=> $stable(std_sel));

endmodule

// File: tb/sim_rate_hunt_ctrl.sv
module sim_rate_hunt_ctrl;
    localparam int DW = 16;
    localparam int HW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          carrier_ok = 1'b0;
    logic          ref_seen = 1'b0;
    logic [DW-1:0] dwell_len = DW'(4);
    logic [HW-1:0] hold_len = HW'(6);
    logic [1:0]    std_sel;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // model state, written from the requirements
    int m_code = 0, m_dwell = 0, m_hold = 0;
    bit m_locked = 0;

    int exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    rate_hunt_ctrl #(.DWELL_W(DW), .HOLD_W(HW)) u0 (
        .clk(clk), .rst(rst), .carrier_ok(carrier_ok), .ref_seen(ref_seen),
        .dwell_len(dwell_len), .hold_len(hold_len), .std_sel(std_sel)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: std_sel=%0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // driver: applies one cycle of inputs at the falling edge, pushes expectation
    task automatic drive(input bit c, input bit r);
        int neff, meff;
        bit hunt;
        @(negedge clk);
        carrier_ok = c;
        ref_seen = r;
        neff = (dwell_len == 0) ? 1 : int'(dwell_len);
        meff = (hold_len == 0) ? 1 : int'(hold_len);
        hunt = c && !m_locked && !r;
        if (hunt) begin
            if (m_dwell == neff - 1) begin
                m_code = (m_code + 1) % 4;
                m_dwell = 0;
            end else m_dwell++;
        end else m_dwell = 0;
        if (r) begin
            m_locked = 1; m_hold = meff;
        end else if (m_locked) begin
            if (m_hold == 1) begin m_locked = 0; m_hold = 0; end
            else m_hold--;
        end
        exp_q.push_back(m_code);
        tag_q.push_back(tag);
    endtask

    task automatic run(input bit c, input int n);
        for (int i = 0; i < n; i++) drive(c, 1'b0);
    endtask

    // monitor: samples after the rising edge, pops and compares
    always @(posedge clk) begin
        #3;
        if (exp_q.size() > 0) begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, int'(std_sel), e);
        end
    end

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1", int'(std_sel), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", int'(std_sel), 0);
        // the model starts from the reset state here (one idle cycle with no carrier)

        tag = "R1"; run(1, 3);          // still 00 before the first full dwell
        tag = "R2"; run(1, 17);         // full wrap with dwell 4
        tag = "R3"; run(1, 2);
        tag = "R4"; run(0, 7);          // no carrier: frozen, dwell cleared
        tag = "R4"; run(1, 6);
        tag = "R5"; drive(1, 1);        // lock
        tag = "R6"; run(1, 10);         // releases after 6, resumes
        tag = "R6";
        for (int k = 0; k < 5; k++) begin
            drive(1, 1);
            run(1, 3);                  // reload before expiry keeps lock
        end
        run(1, 12);
        // R8: reference on the exact edge where the dwell would expire
        tag = "R8"; run(0, 1); run(1, 3); drive(1, 1); run(1, 10);
        // R9: carrier drops during a lock; hold time keeps counting
        tag = "R9"; drive(1, 1); run(0, 3); run(1, 8); run(0, 8); run(1, 5);
        // R7: zero lengths act as one
        tag = "R7"; run(0, 1);
        dwell_len = '0; hold_len = '0;
        run(1, 9); drive(1, 1); run(1, 6);
        drive(0, 1); drive(1, 0); run(1, 4);
        // different dwell for R3
        tag = "R3"; run(0, 1);
        dwell_len = DW'(7); hold_len = HW'(3);
        run(1, 30);
        drive(1, 1); run(1, 12);
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule